// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Pin Interrupts

This block controls 64 general-purpose pins split into two 32-bit banks; pin n lives in bank n/32 at bit n%32. Each pin has a direction bit, an alternate-function select bit and an output data bit. A set select bit hands the pad's output and output enable to an alternate-function source. Every pad input passes through a two-flop synchroniser. The synchronised level can be read back in both banks, whatever the pin's direction.

The lowest 16 pins can also raise interrupts. Each has three mode bits: an edge flag, a high-polarity flag and a low-polarity flag. A detected event sets a sticky pending bit. The pending bit is cleared by raising its clear bit and later lowering it. The pending bits that are enabled are ORed into a single registered interrupt line. All access goes through a simple word bus: an address, a write strobe, write data, and combinational read data.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Word addresses are: 0/1 direction bank 0/1, 2/3 select bank 0/1, 4/5 output data bank 0/1, 6/7 input bank 0/1 (read-only), 8 edge flags, 9 high flags, 10 low flags, 11 enable, 12 clear, 13 pending (read-only); any other address reads 0. A write with bus_we high takes effect at the clock edge, and a read returns the stored value. The output data register returns the value written, not the pad level.
- R2: With select 0, pad_out follows the output data bit and pad_oe follows the direction bit (1 means output).
- R3: With select 1, pad_out and pad_oe follow alt_out and alt_oe for that pin.
- R4: The input registers return pad_in delayed by two clock edges, for inputs and outputs alike.
- R5: Mode (edge,high,low) = 0,1,0 sets pending while the synchronised level is 1. Mode 0,0,1 sets pending while it is 0.
- R6: Mode 1,1,0 sets pending on a rising edge, 1,0,1 on a falling edge, and 1,1,1 on either edge. An edge is a change between the previous and the current synchronised value. Modes 0,0,0 and 1,0,0 never set pending.
- R7: Pending bits hold until their clear bit is 1. While the clear bit is 1, the pending bit is forced to 0. A level condition that still holds after the clear bit returns to 0 sets the pending bit again.
- R8: irq is 1 exactly one cycle after any pending bit whose enable bit is 1.
- R9: Only pins 0 to 15 can interrupt. The interrupt registers keep 16 bits, and their upper bits read 0.
- R10: After reset, every register, synchroniser stage, the pending bits and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 64 | Raw pad levels |
| pad_out | output | 64 | Pad output data |
| pad_oe | output | 64 | Pad output enable |
| alt_out | input | 64 | Alternate-function output data |
| alt_oe | input | 64 | Alternate-function output enable |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: 32-bit banks and 16 interrupt pins. This lets it drive the bank boundary at pin 32 and a pin above 15 that toggles without ever interrupting. At the 16-bit interrupt width it gives every one of the six modes, plus the unused edge-only code, a pin of its own. The modes, the clear pulse and the enable mask can then be exercised side by side in the same cycles.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int BANK_W = 32,
  parameter int IRQ_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [BANK_W-1:0]   bus_wdata,
  output logic [BANK_W-1:0]   bus_rdata,
  input  logic [2*BANK_W-1:0] pad_in,
  output logic [2*BANK_W-1:0] pad_out,
  output logic [2*BANK_W-1:0] pad_oe,
  input  logic [2*BANK_W-1:0] alt_out,
  input  logic [2*BANK_W-1:0] alt_oe,
  output logic                irq
);
  localparam int NPIN = 2 * BANK_W;
  localparam logic [ADDR_W-1:0] A_DIR  = 0;
  localparam logic [ADDR_W-1:0] A_SEL  = 2;
  localparam logic [ADDR_W-1:0] A_OUT  = 4;
  localparam logic [ADDR_W-1:0] A_IN   = 6;
  localparam logic [ADDR_W-1:0] A_EDGE = 8;
  localparam logic [ADDR_W-1:0] A_HI   = 9;
  localparam logic [ADDR_W-1:0] A_LO   = 10;
  localparam logic [ADDR_W-1:0] A_EN   = 11;
  localparam logic [ADDR_W-1:0] A_CLR  = 12;
  localparam logic [ADDR_W-1:0] A_PEND = 13;

  logic [NPIN-1:0]  dir_q, sel_q, out_q;
  logic [NPIN-1:0]  sync1_q, sync2_q, prev_q;
  logic [IRQ_W-1:0] edge_q, hi_q, lo_q, en_q, clr_q, pend_q;
  logic [IRQ_W-1:0] cur, old, lvl_ev, edg_ev;

  genvar b;
  generate
    for (b = 0; b < 2; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dir_q[b*BANK_W +: BANK_W] <= '0;
          sel_q[b*BANK_W +: BANK_W] <= '0;
          out_q[b*BANK_W +: BANK_W] <= '0;
        end else if (bus_we) begin
          if (bus_addr == A_DIR + ADDR_W'(b)) dir_q[b*BANK_W +: BANK_W] <= bus_wdata;
          if (bus_addr == A_SEL + ADDR_W'(b)) sel_q[b*BANK_W +: BANK_W] <= bus_wdata;
          if (bus_addr == A_OUT + ADDR_W'(b)) out_q[b*BANK_W +: BANK_W] <= bus_wdata;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      en_q   <= '0;
      clr_q  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_EDGE:  edge_q <= bus_wdata[IRQ_W-1:0];
        A_HI:    hi_q   <= bus_wdata[IRQ_W-1:0];
        A_LO:    lo_q   <= bus_wdata[IRQ_W-1:0];
        A_EN:    en_q   <= bus_wdata[IRQ_W-1:0];
        A_CLR:   clr_q  <= bus_wdata[IRQ_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign cur    = sync2_q[IRQ_W-1:0];
  assign old    = prev_q[IRQ_W-1:0];
  assign lvl_ev = ~edge_q & ((hi_q & cur) | (lo_q & ~cur));
  assign edg_ev = edge_q & ((hi_q & cur & ~old) | (lo_q & ~cur & old));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq    <= 1'b0;
    end else begin
      pend_q <= (pend_q | lvl_ev | edg_ev) & ~clr_q;
      irq    <= |(pend_q & en_q);
    end
  end

  assign pad_out = (sel_q & alt_out) | (~sel_q & out_q);
  assign pad_oe  = (sel_q & alt_oe)  | (~sel_q & dir_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DIR:      bus_rdata = dir_q[BANK_W-1:0];
      A_DIR + 1:  bus_rdata = dir_q[NPIN-1:BANK_W];
      A_SEL:      bus_rdata = sel_q[BANK_W-1:0];
      A_SEL + 1:  bus_rdata = sel_q[NPIN-1:BANK_W];
      A_OUT:      bus_rdata = out_q[BANK_W-1:0];
      A_OUT + 1:  bus_rdata = out_q[NPIN-1:BANK_W];
      A_IN:       bus_rdata = sync2_q[BANK_W-1:0];
      A_IN + 1:   bus_rdata = sync2_q[NPIN-1:BANK_W];
      A_EDGE:     bus_rdata[IRQ_W-1:0] = edge_q;
      A_HI:       bus_rdata[IRQ_W-1:0] = hi_q;
      A_LO:       bus_rdata[IRQ_W-1:0] = lo_q;
      A_EN:       bus_rdata[IRQ_W-1:0] = en_q;
      A_CLR:      bus_rdata[IRQ_W-1:0] = clr_q;
      A_PEND:     bus_rdata[IRQ_W-1:0] = pend_q;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int IRQ_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IRQ_W-1:0] pend,
  input logic [IRQ_W-1:0] clr,
  input logic [IRQ_W-1:0] en,
  input logic [IRQ_W-1:0] m_edge,
  input logic [IRQ_W-1:0] m_hi,
  input logic [IRQ_W-1:0] m_lo,
  input logic [IRQ_W-1:0] lvl,
  input logic             irq
);
  logic [IRQ_W-1:0] hi_lvl_hit;
  logic [IRQ_W-1:0] dead_mode;
  assign hi_lvl_hit = ~m_edge & m_hi & ~m_lo & lvl & ~clr;
  assign dead_mode  = ~m_hi & ~m_lo;

  a_r7_clear_forces_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr) |=> ((pend & $past(clr)) == '0));

  a_r8_no_enabled_pending_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & en) == '0) |=> !irq);

  a_r6_dead_modes_never_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & $past(dead_mode)) == '0));

  a_r5_high_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(hi_lvl_hit)) == $past(hi_lvl_hit)));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend(pend_q), .clr(clr_q), .en(en_q),
  .m_edge(edge_q), .m_hi(hi_q), .m_lo(lo_q), .lvl(cur), .irq(irq)
);

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] pad_in = '0, alt_out = '0, alt_oe = '0;
  logic [63:0] pad_out, pad_oe;
  logic        irq;

  int nvec = 0, nbad = 0;

  logic [63:0] m_dir = '0, m_sel = '0, m_out = '0, m_s1 = '0, m_s2 = '0, m_prev = '0;
  logic [15:0] m_e = '0, m_h = '0, m_l = '0, m_en = '0, m_clr = '0, m_p = '0;
  logic        m_irq = 1'b0;

  always #(PER/2) clk = ~clk;

  gpio_irq_ctrl uut (.*);

  function automatic logic [31:0] model_rd(input logic [3:0] a);
    case (a)
      0: return m_dir[31:0];  1: return m_dir[63:32];
      2: return m_sel[31:0];  3: return m_sel[63:32];
      4: return m_out[31:0];  5: return m_out[63:32];
      6: return m_s2[31:0];   7: return m_s2[63:32];
      8: return {16'h0, m_e}; 9: return {16'h0, m_h};
      10: return {16'h0, m_l}; 11: return {16'h0, m_en};
      12: return {16'h0, m_clr}; 13: return {16'h0, m_p};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    logic [63:0] eo, ee;
    for (int i = 0; i < 64; i++) begin
      eo[i] = m_sel[i] ? alt_out[i] : m_out[i];
      ee[i] = m_sel[i] ? alt_oe[i] : m_dir[i];
    end
    check("R2/R3 pad_out", pad_out, eo);
    check("R2/R3 pad_oe", pad_oe, ee);
    check("R8 irq", {63'h0, irq}, {63'h0, m_irq});
    check("R1/R4/R9 bus_rdata", {32'h0, bus_rdata}, {32'h0, model_rd(bus_addr)});
  endtask

  task automatic tick();
    logic [15:0] np;
    logic ev, c, o, ni;
    for (int i = 0; i < 16; i++) begin
      c = m_s2[i]; o = m_prev[i];
      if (!m_e[i]) ev = (m_h[i] && c) || (m_l[i] && !c);
      else         ev = (m_h[i] && c && !o) || (m_l[i] && !c && o);
      np[i] = m_clr[i] ? 1'b0 : (m_p[i] || ev);
    end
    ni = |(m_p & m_en);
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
    if (bus_we) begin
      case (bus_addr)
        0: m_dir[31:0] = bus_wdata;  1: m_dir[63:32] = bus_wdata;
        2: m_sel[31:0] = bus_wdata;  3: m_sel[63:32] = bus_wdata;
        4: m_out[31:0] = bus_wdata;  5: m_out[63:32] = bus_wdata;
        8: m_e = bus_wdata[15:0];    9: m_h = bus_wdata[15:0];
        10: m_l = bus_wdata[15:0];   11: m_en = bus_wdata[15:0];
        12: m_clr = bus_wdata[15:0];
        default: ;
      endcase
    end
    m_p = np; m_irq = ni;
    @(posedge clk);
    #(PER/4);
    compare();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    bus_addr = a;
    tick();
  endtask

  initial begin
    #(PER * 200000);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    pad_in = 64'hFFFF_0000_A5A5_FFFF;
    repeat (3) @(posedge clk);
    #(PER/4);
    compare(); // R10 reset state
    @(negedge clk);
    rst_n = 1'b1;
    pad_in = '0;
    for (int a = 0; a < 16; a++) rd(4'(a)); // R10 all registers zero

    // R1 readback across both banks, R2 direction drive
    wr(0, 32'hDEAD_BEEF); wr(1, 32'h1234_5678);
    wr(4, 32'h0F0F_00FF); wr(5, 32'hCAFE_F00D);
    pad_in = 64'h5555_AAAA_3333_CCCC; // R1 output reads ignore pads
    for (int a = 0; a < 8; a++) rd(4'(a));
    // R3 alternate-function routing on pins in both banks
    alt_out = 64'hFFFF_0000_FFFF_0000; alt_oe = 64'h0000_FFFF_0000_FFFF;
    wr(2, 32'h00FF_FF00); wr(3, 32'h8000_0001);
    rd(2); alt_out = ~alt_out; rd(3);
    // R4 input sync, including on output pins
    pad_in = 64'h0123_4567_89AB_CDEF;
    rd(6); rd(6); rd(6); rd(7);

    // R9 upper interrupt bits read zero
    wr(8, 32'hFFFF_FFFF); rd(8);
    wr(8, 32'h0); wr(13, 32'hFFFF); rd(13);

    // R5/R6 mode per pin: 0 low,1 high,2 rise,3 fall,4 both,5 edge-only,6 none
    pad_in = 64'h0000_0000_0000_0000;
    wr(8,  32'h0000_003C);
    wr(9,  32'h0000_0016);
    wr(10, 32'h0000_0019);
    wr(11, 32'h0000_00FF);
    for (int k = 0; k < 4; k++) rd(13);
    wr(12, 32'hFFFF); wr(12, 32'h0); // R7 clear, low pin 0 re-sets
    for (int k = 0; k < 4; k++) rd(13);
    pad_in = 64'h0001_0000_0000_007F; // rising; pin 48 ignored (R9)
    for (int k = 0; k < 5; k++) rd(13);
    wr(12, 32'h0000_007F); wr(12, 32'h0); rd(13); rd(13);
    pad_in = 64'h0;                     // falling
    for (int k = 0; k < 5; k++) rd(13);
    wr(11, 32'h0); rd(13); rd(13);       // R8 irq drops with enable off
    wr(11, 32'h0000_0010); rd(13); rd(13);
    wr(12, 32'hFFFF); rd(13); rd(13); wr(12, 32'h0); rd(13);

    // pin 20 toggles, never interrupts (R9)
    for (int k = 0; k < 6; k++) begin pad_in[20] = ~pad_in[20]; rd(13); end

    // random phase covering all requirements together
    for (int k = 0; k < 1500; k++) begin
      pad_in = {$urandom, $urandom};
      alt_out = {$urandom, $urandom};
      alt_oe  = {$urandom, $urandom};
      if (($urandom % 4) == 0) wr(4'($urandom % 14), $urandom);
      else rd(4'($urandom % 16));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule